// File: doc/BRIEF.md
# Conditional Nonvolatile Store Controller

This block sequences the copy of a volatile memory array into its nonvolatile shadow, and the copy back at power-up. Four events can ask for a store: a falling edge on an active-low hardware request pin, a rising power-fail flag (only while automatic store is enabled), a one-cycle software store command and a one-cycle sleep command. A store only reaches the array when at least one accepted memory write has happened since the last store or recall. Otherwise the trigger finishes without touching the array.

The array itself is outside the block. A one-cycle start pulse asks it to store or recall, and a one-cycle done pulse reports that it has finished. The controller drives two status pins. One pulls low while a store runs. The other drives high for a short interval after a hardware or software store, and both are released otherwise. A memory-inhibit output gates the memory port. Every interval is a clock-cycle count parameter, timed by one shared loadable counter.

Top module: `nvstore_ctrl`

## Requirements
- R1: After reset the block pulses `arr_recall_go` once. `mem_inhibit` stays high from reset until `arr_done` ends the recall, and memory writes made during that time are not counted.
- R2: A trigger starts a store (`arr_store_go` pulse) only if a write was accepted (`mem_wr` high while `mem_inhibit` low) since the last completed store or recall. Otherwise no store pulse occurs and the block returns to idle.
- R3: A falling edge of `hw_req_n` in idle starts a wait of DLY_CYC cycles, during which memory is inhibited. The conditional store is decided at the end of that wait.
- R4: `mem_inhibit` is high for the whole store and in every cycle in which `hw_req_n` is low, whichever lasts longer.
- R5: `stat_pull_low` is high from the `arr_store_go` cycle until `arr_done`, whatever the source: ST_LAT+1 cycles for an array that answers ST_LAT cycles after the start.
- R6: After a hardware or software store, `stat_drive_high` is high for HHD_CYC cycles. It is never high after a power-fail or sleep store, and never together with `stat_pull_low`.
- R7: After a hardware, software or power-fail store, memory stays inhibited for LZ_CYC further cycles once the status pins are idle.
- R8: A rising `pwr_fail` while `auto_store_en` is high raises `mem_inhibit` in the same cycle and starts a conditional store. A write made in that same cycle is rejected.
- R9: `auto_off_cmd` clears `auto_store_en` until the next reset and inhibits memory for SS_CYC cycles. While `auto_store_en` is low, `pwr_fail` neither inhibits memory nor stores.
- R10: A trigger that arrives while a store or recall is running is dropped, not queued, and a write in that time is rejected.
- R11: `sleep_cmd` performs a conditional store and then enters sleep (`asleep` high, memory inhibited). A clean array enters sleep at once, and `wake_cmd` returns the block to idle.
- R12: A write accepted in the same cycle as a software store or sleep command counts toward that trigger's store decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_n | input | 1 | Active-low hardware store request |
| pwr_fail | input | 1 | Supply-drop comparator flag |
| sw_store_cmd | input | 1 | One-cycle software store command |
| sleep_cmd | input | 1 | One-cycle sleep entry command |
| auto_off_cmd | input | 1 | One-cycle command that disables automatic store |
| wake_cmd | input | 1 | One-cycle wake request while asleep |
| mem_wr | input | 1 | Memory write strobe |
| arr_done | input | 1 | Array operation finished |
| arr_store_go | output | 1 | Start pulse for an array store |
| arr_recall_go | output | 1 | Start pulse for an array recall |
| stat_pull_low | output | 1 | Status pin pulled low (busy) |
| stat_drive_high | output | 1 | Status pin actively driven high |
| mem_inhibit | output | 1 | Memory port access blocked |
| auto_store_en | output | 1 | Automatic store on power fail enabled |
| asleep | output | 1 | Block is in sleep |

## Verification
The collision of interest is a memory write strobe landing in the same cycle as a trigger. With a software command the write is accepted and must tip a clean array into a real store. With a power-fail edge the inhibit rises combinationally and the write must be lost, so the store is skipped. The bench applies both on a clean array and judges the outcome from whether a store pulse reaches the scoreboard. A later software command then reveals the dirty state that is left over. The same approach covers triggers and writes injected while a store is already running.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RCL_GO,
        ST_RCL_WAIT,
        ST_IDLE,
        ST_HW_DLY,
        ST_STO_GO,
        ST_STO_WAIT,
        ST_DRV_HI,
        ST_POST,
        ST_SETTLE,
        ST_SLEEP
    } nvs_state_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PFAIL,
        SRC_HWREQ,
        SRC_SWCMD,
        SRC_SLEEP,
        SRC_AUTOOFF
    } nvs_src_t;

    typedef struct packed {
        logic     valid;
        nvs_src_t src;
    } nvs_trig_t;

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // sources whose store ends with an actively driven high status pin
    function automatic logic src_drives_high(nvs_src_t s);
        return (s == SRC_HWREQ) || (s == SRC_SWCMD);
    endfunction

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
    input  logic clk,
    input  logic rst,
    input  logic wr_strobe,
    input  logic inhibit,
    input  logic clr,
    output logic dirty,
    output logic dirty_eff
);
    logic wr_ok;

    assign wr_ok     = wr_strobe && !inhibit;
    assign dirty_eff = dirty || wr_ok;

    always_ff @(posedge clk) begin
        if (rst) dirty <= 1'b0;
        else     dirty <= wr_ok || (dirty && !clr);
    end
endmodule

// File: rtl/nvs_trig.sv
module nvs_trig
    import nvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hw_req_n,
    input  logic      pwr_fail,
    input  logic      sw_cmd,
    input  logic      sleep_cmd,
    input  logic      auto_off_cmd,
    input  logic      auto_en,
    output nvs_trig_t trig
);
    logic hw_prev, pf_prev;
    logic hw_fall, pf_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_prev <= 1'b1;
            pf_prev <= 1'b0;
        end else begin
            hw_prev <= hw_req_n;
            pf_prev <= pwr_fail;
        end
    end

    assign hw_fall = hw_prev && !hw_req_n;
    assign pf_rise = pwr_fail && !pf_prev && auto_en;

    // fixed priority: power fail, hardware pin, software, sleep, auto-off
    always_comb begin
        trig.valid = 1'b1;
        if (pf_rise)           trig.src = SRC_PFAIL;
        else if (hw_fall)      trig.src = SRC_HWREQ;
        else if (sw_cmd)       trig.src = SRC_SWCMD;
        else if (sleep_cmd)    trig.src = SRC_SLEEP;
        else if (auto_off_cmd) trig.src = SRC_AUTOOFF;
        else begin
            trig.valid = 1'b0;
            trig.src   = SRC_NONE;
        end
    end
endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl
    import nvs_pkg::*;
#(
    parameter int unsigned DLY_CYC = 16,
    parameter int unsigned HHD_CYC = 4,
    parameter int unsigned LZ_CYC  = 8,
    parameter int unsigned SS_CYC  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_req_n,
    input  logic pwr_fail,
    input  logic sw_store_cmd,
    input  logic sleep_cmd,
    input  logic auto_off_cmd,
    input  logic wake_cmd,
    input  logic mem_wr,
    input  logic arr_done,
    output logic arr_store_go,
    output logic arr_recall_go,
    output logic stat_pull_low,
    output logic stat_drive_high,
    output logic mem_inhibit,
    output logic auto_store_en,
    output logic asleep
);
    localparam int unsigned CNT_MAX = max_of4(DLY_CYC, HHD_CYC, LZ_CYC, SS_CYC);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LD_DLY = CW'(DLY_CYC - 1);
    localparam logic [CW-1:0] LD_HHD = CW'(HHD_CYC - 1);
    localparam logic [CW-1:0] LD_LZ  = CW'(LZ_CYC - 1);
    localparam logic [CW-1:0] LD_SS  = CW'(SS_CYC - 1);

    nvs_state_t state, nxt;
    nvs_src_t   src_q;
    nvs_trig_t  trig;
    logic       take;
    logic       tmr_load, tmr_exp;
    logic [CW-1:0] tmr_val;
    logic       dirty, dirty_eff, dirty_clr;
    logic       auto_en;

    nvs_trig u_trig (
        .clk(clk), .rst(rst), .hw_req_n(hw_req_n), .pwr_fail(pwr_fail),
        .sw_cmd(sw_store_cmd), .sleep_cmd(sleep_cmd),
        .auto_off_cmd(auto_off_cmd), .auto_en(auto_en), .trig(trig)
    );

    nvs_timer #(.W(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_exp)
    );

    assign dirty_clr = arr_done &&
                       ((state == ST_STO_WAIT) || (state == ST_RCL_WAIT));

    nvs_dirty u_dirty (
        .clk(clk), .rst(rst), .wr_strobe(mem_wr), .inhibit(mem_inhibit),
        .clr(dirty_clr), .dirty(dirty), .dirty_eff(dirty_eff)
    );

    always_comb begin
        nxt      = state;
        take     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_BOOT:     nxt = ST_RCL_GO;
            ST_RCL_GO:   nxt = ST_RCL_WAIT;
            ST_RCL_WAIT: if (arr_done) nxt = ST_IDLE;
            ST_IDLE: begin
                if (trig.valid) begin
                    take = 1'b1;
                    case (trig.src)
                        SRC_HWREQ: begin
                            nxt = ST_HW_DLY; tmr_load = 1'b1; tmr_val = LD_DLY;
                        end
                        SRC_AUTOOFF: begin
                            nxt = ST_SETTLE; tmr_load = 1'b1; tmr_val = LD_SS;
                        end
                        SRC_SLEEP: nxt = dirty_eff ? ST_STO_GO : ST_SLEEP;
                        default:   nxt = dirty_eff ? ST_STO_GO : ST_IDLE;
                    endcase
                end
            end
            ST_HW_DLY:  if (tmr_exp) nxt = dirty_eff ? ST_STO_GO : ST_IDLE;
            ST_STO_GO:  nxt = ST_STO_WAIT;
            ST_STO_WAIT: begin
                if (arr_done) begin
                    if (src_q == SRC_SLEEP) begin
                        nxt = ST_SLEEP;
                    end else if (src_drives_high(src_q)) begin
                        nxt = ST_DRV_HI; tmr_load = 1'b1; tmr_val = LD_HHD;
                    end else begin
                        nxt = ST_POST; tmr_load = 1'b1; tmr_val = LD_LZ;
                    end
                end
            end
            ST_DRV_HI: begin
                if (tmr_exp) begin
                    nxt = ST_POST; tmr_load = 1'b1; tmr_val = LD_LZ;
                end
            end
            ST_POST, ST_SETTLE: if (tmr_exp) nxt = ST_IDLE;
            ST_SLEEP:  if (wake_cmd) nxt = ST_IDLE;
            default:   nxt = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_BOOT;
            src_q   <= SRC_NONE;
            auto_en <= 1'b1;
        end else begin
            state <= nxt;
            if (take) src_q <= trig.src;
            if (take && trig.src == SRC_AUTOOFF) auto_en <= 1'b0;
        end
    end

    assign arr_store_go    = (state == ST_STO_GO);
    assign arr_recall_go   = (state == ST_RCL_GO);
    assign stat_pull_low   = (state == ST_STO_GO) || (state == ST_STO_WAIT);
    assign stat_drive_high = (state == ST_DRV_HI);
    assign asleep          = (state == ST_SLEEP);
    assign auto_store_en   = auto_en;
    assign mem_inhibit     = (state != ST_IDLE) || !hw_req_n || (pwr_fail && auto_en);

    // R1
    recall_single_chk: assert property (@(posedge clk) disable iff (rst)
        arr_recall_go |=> (!arr_recall_go && mem_inhibit));
    // R2
    store_needs_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        arr_store_go |-> dirty);
    // R4
    busy_inhibits_chk: assert property (@(posedge clk) disable iff (rst)
        stat_pull_low |-> mem_inhibit);
    // R5
    busy_after_go_chk: assert property (@(posedge clk) disable iff (rst)
        arr_store_go |=> stat_pull_low);
    // R6
    drive_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat_pull_low && stat_drive_high));
    // R8
    pfail_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_fail && auto_store_en) |-> mem_inhibit);
    // R9
    auto_off_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_store_en |=> !auto_store_en);
endmodule

// File: tb/nvstore_ctrl_test.sv
module nvstore_ctrl_test;
    localparam int DLY = 4, HHD = 2, LZ = 3, SS = 5, LAT = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic hw_req_n = 1'b1, pwr_fail = 1'b0, sw_store_cmd = 1'b0, sleep_cmd = 1'b0;
    logic auto_off_cmd = 1'b0, wake_cmd = 1'b0, mem_wr = 1'b0, arr_done;
    logic arr_store_go, arr_recall_go, stat_pull_low, stat_drive_high;
    logic mem_inhibit, auto_store_en, asleep;

    int checks = 0, failures = 0;
    int exp_q[$];   // 1 = store expected, 2 = recall expected
    int nb, nh, np, ns;

    always #10 clk = ~clk;

    nvstore_ctrl #(.DLY_CYC(DLY), .HHD_CYC(HHD), .LZ_CYC(LZ), .SS_CYC(SS)) uut (
        .clk(clk), .rst(rst), .hw_req_n(hw_req_n), .pwr_fail(pwr_fail),
        .sw_store_cmd(sw_store_cmd), .sleep_cmd(sleep_cmd),
        .auto_off_cmd(auto_off_cmd), .wake_cmd(wake_cmd), .mem_wr(mem_wr),
        .arr_done(arr_done), .arr_store_go(arr_store_go),
        .arr_recall_go(arr_recall_go), .stat_pull_low(stat_pull_low),
        .stat_drive_high(stat_drive_high), .mem_inhibit(mem_inhibit),
        .auto_store_en(auto_store_en), .asleep(asleep)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_store();
        exp_q.push_back(1);
    endtask

    // counts busy, drive-high and other inhibited cycles until access reopens
    task automatic measure(output int b, output int h, output int p, output int s);
        b = 0; h = 0; p = 0; s = 0;
        for (int i = 0; i < 200; i++) begin
            if (!mem_inhibit || asleep) break;
            if (stat_pull_low) b++;
            else if (stat_drive_high) h++;
            else p++;
            if (arr_store_go) s++;
            @(negedge clk);
        end
    endtask

    task automatic write_once();
        mem_wr = 1'b1; tick(1); mem_wr = 1'b0;
    endtask

    // array model: answers every start pulse LAT cycles later
    initial begin
        arr_done = 1'b0;
        forever begin
            @(negedge clk);
            if (arr_store_go || arr_recall_go) begin
                tick(LAT);
                arr_done = 1'b1;
                tick(1);
                arr_done = 1'b0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (arr_store_go || arr_recall_go) begin
                int got;
                got = arr_store_go ? 1 : 2;
                if (exp_q.size() == 0) chk("R2 unexpected array op", got, 0);
                else chk("R2 array op order", got, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_q.push_back(2);
        tick(3);
        // R1 reset state
        chk("R1 inhibit in reset", mem_inhibit, 1);
        chk("R1 no recall in reset", arr_recall_go, 0);
        chk("R6 status released in reset", stat_pull_low | stat_drive_high, 0);
        chk("R9 auto enabled after reset", auto_store_en, 1);
        rst = 1'b0;
        mem_wr = 1'b1; tick(2); mem_wr = 1'b0;   // during recall: rejected
        tick(LAT + 2);
        chk("R1 access open after recall", mem_inhibit, 0);
        chk("R1 one recall", exp_q.size(), 0);

        // R2 clean array: trigger skipped
        sw_store_cmd = 1'b1; tick(1); sw_store_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R2 clean skip busy", nb, 0);
        chk("R1 recall-time write ignored", ns, 0);

        // software store timing: R5 R6 R7
        write_once(); expect_store();
        sw_store_cmd = 1'b1; tick(1); sw_store_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R5 busy cycles sw", nb, LAT + 1);
        chk("R6 drive-high cycles sw", nh, HHD);
        chk("R7 post inhibit sw", np, LZ);

        // R12 write in same cycle as software command
        mem_wr = 1'b1; sw_store_cmd = 1'b1; expect_store();
        tick(1); mem_wr = 1'b0; sw_store_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R12 same-cycle write stores", ns, 1);

        // R3 hardware request with delay
        write_once(); expect_store();
        hw_req_n = 1'b0; tick(1); hw_req_n = 1'b1;
        measure(nb, nh, np, ns);
        chk("R3 delay plus post", np, DLY + LZ);
        chk("R3 busy cycles hw", nb, LAT + 1);
        chk("R6 drive-high cycles hw", nh, HHD);

        // R4 pin held low beyond a skipped store
        hw_req_n = 1'b0; tick(DLY + 3);
        chk("R4 inhibit while pin low", mem_inhibit, 1);
        hw_req_n = 1'b1; #1;
        chk("R4 release reopens", mem_inhibit, 0);
        tick(1);

        // R10 triggers and write during a store are dropped
        write_once(); expect_store();
        sw_store_cmd = 1'b1; tick(1);
        mem_wr = 1'b1; hw_req_n = 1'b0;
        tick(1); sw_store_cmd = 1'b0; mem_wr = 1'b0; hw_req_n = 1'b1;
        tick(LAT + HHD + LZ + DLY + 6);
        chk("R10 nothing queued", exp_q.size(), 0);
        sw_store_cmd = 1'b1; tick(1); sw_store_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R10 busy write rejected", ns, 0);

        // R8 power fail store
        write_once(); expect_store();
        pwr_fail = 1'b1; #1;
        chk("R8 immediate inhibit", mem_inhibit, 1);
        tick(1); pwr_fail = 1'b0;
        measure(nb, nh, np, ns);
        chk("R8 busy cycles pf", nb, LAT + 1);
        chk("R6 no drive-high pf", nh, 0);
        chk("R7 post inhibit pf", np, LZ);

        // R8 write colliding with power-fail edge is lost
        pwr_fail = 1'b1; mem_wr = 1'b1; tick(1);
        pwr_fail = 1'b0; mem_wr = 1'b0; tick(3);
        sw_store_cmd = 1'b1; tick(1); sw_store_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R8 same-cycle write rejected", ns, 0);

        // R11 sleep with dirty array
        write_once(); expect_store();
        sleep_cmd = 1'b1; tick(1); sleep_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R11 store before sleep", nb, LAT + 1);
        chk("R11 asleep", asleep, 1);
        chk("R11 inhibited asleep", mem_inhibit, 1);
        write_once();
        wake_cmd = 1'b1; tick(1); wake_cmd = 1'b0;
        chk("R11 awake", asleep, 0);
        chk("R11 access after wake", mem_inhibit, 0);
        sleep_cmd = 1'b1; tick(1); sleep_cmd = 1'b0;
        chk("R11 clean sleep direct", asleep, 1);
        chk("R11 clean sleep no busy", stat_pull_low, 0);
        wake_cmd = 1'b1; tick(1); wake_cmd = 1'b0;

        // R9 auto-store disable
        auto_off_cmd = 1'b1; tick(1); auto_off_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R9 settle cycles", np, SS);
        chk("R9 auto disabled", auto_store_en, 0);
        mem_wr = 1'b1; pwr_fail = 1'b1; #1;
        chk("R9 pf no inhibit when off", mem_inhibit, 0);
        tick(1); mem_wr = 1'b0; pwr_fail = 1'b0;
        tick(10);
        expect_store();
        sw_store_cmd = 1'b1; tick(1); sw_store_cmd = 1'b0;
        measure(nb, nh, np, ns);
        chk("R9 pf did not store", ns, 1);
        chk("R9 still disabled", auto_store_en, 0);

        tick(3);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule